// File: doc/BRIEF.md
# Memory-Card Event Latch Register

This block is a small register slice that tells software about a removable memory card. It watches two signals from the card slot logic: a write-protect level and a card-insertion event. The write-protect state is copied into a status bit on every clock, so software always sees the current tab position. A card insertion is caught in a sticky status bit that stays set after the event signal falls. While that bit is set, the block holds an interrupt line high towards a secondary interrupt controller.

Software reaches the block through a simple single-cycle register port with a word address. Reads return data in the same cycle. A write to the status word with the card bit set in the data removes the latched insertion and drops the interrupt. Two further words return fixed identification and decode constants. One word reads as zero and ignores writes. Any access outside the four defined words returns zero and raises a one-cycle error pulse.

Top module: `card_evt_latch`

## Requirements
- R1: While reset is held and after it is released, the status word (word 2) reads zero, `card_irq` is low and `bus_err` is low.
- R2: Status bit 0 (write-protect) equals the level that `wp_in` had at the previous rising clock edge, whatever has been written to the block.
- R3: Status bit 3 (card present) becomes 1 at the clock edge after `card_in` is sampled high, and stays 1 after `card_in` returns low.
- R4: `card_irq` is high exactly when status bit 3 is 1.
- R5: A write to word 2 whose data has bit 3 set clears status bit 3 at that clock edge, and `card_irq` is low in the following cycle. A write to word 2 with data bit 3 clear leaves bit 3 unchanged. No write changes status bit 0.
- R6: If `card_in` is high at the same edge as a clearing write to word 2, status bit 3 stays 1 and `card_irq` stays high.
- R7: Word 0 reads the identification constant 0x5A17_0C03, word 1 reads 0 and word 3 reads 0x0000_0011.
- R8: Writes to word 1 and word 3 change neither any read value nor `card_irq`, and do not raise `bus_err`.
- R9: An access (read or write) to any word address of 4 or above reads 0, and `bus_err` is high for exactly the one cycle after the access edge. Accesses to words 0 to 3 never raise `bus_err`.
- R10: Status bits other than bit 0 and bit 3 always read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Access strobe, one access per cycle while high |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of the access |
| bus_err | output | 1 | Bad-access pulse, high in the cycle after an undefined address |
| wp_in | input | 1 | Write-protect level from the card slot |
| card_in | input | 1 | Card-insertion event from the card slot |
| card_irq | output | 1 | Interrupt request, high while a card event is latched |

## Verification
The bench aims at the cycle where an insertion and a clearing write coincide: a design that let the clear win would drop the interrupt and lose the event. It writes to the status word with bit 3 clear but every other bit set, which catches a design that clears on any status write or lets the write disturb the write-protect bit. It checks that the card bit stays set after the event input falls, which a level-following design would miss. It also accesses addresses just above the defined words and checks that the error pulse is one cycle long and that writes to the two constant words leave every readback alone.

// File: rtl/cdl_pkg.sv
package cdl_pkg;
  localparam int WORD_ID   = 0;
  localparam int WORD_ZERO = 1;
  localparam int WORD_STAT = 2;
  localparam int WORD_DEC  = 3;
  localparam int NUM_WORDS = 4;
  localparam int WP_POS    = 0;
  localparam int CARD_POS  = 3;

  typedef struct packed {
    logic id;
    logic zero;
    logic stat;
    logic dec;
    logic bad;
  } word_hit_t;
endpackage

// File: rtl/cdl_decode.sv
module cdl_decode
  import cdl_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic              sel,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wdata_card,
  output word_hit_t         hit,
  output logic              clr_card
);
  localparam logic [ADDR_W-1:0] A_ID   = ADDR_W'(WORD_ID);
  localparam logic [ADDR_W-1:0] A_ZERO = ADDR_W'(WORD_ZERO);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(WORD_STAT);
  localparam logic [ADDR_W-1:0] A_DEC  = ADDR_W'(WORD_DEC);

  always_comb begin
    hit      = '0;
    clr_card = 1'b0;
    if (sel) begin
      unique case (addr)
        A_ID:    hit.id   = 1'b1;
        A_ZERO:  hit.zero = 1'b1;
        A_STAT:  hit.stat = 1'b1;
        A_DEC:   hit.dec  = 1'b1;
        default: hit.bad  = 1'b1;
      endcase
      clr_card = hit.stat & wr & wdata_card;
    end
  end
endmodule

// File: rtl/cdl_status.sv
module cdl_status (
  input  logic clk,
  input  logic rst_q_n,
  input  logic wp_in,
  input  logic card_in,
  input  logic clr_card,
  output logic wp_q,
  output logic card_q
);
  logic wp_d;
  logic card_d;
  logic card_en;

  always_comb begin
    wp_d    = wp_in;
    card_en = card_in | clr_card;
    // insertion has priority over a same-cycle clear
    card_d  = card_in ? 1'b1 : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      wp_q   <= 1'b0;
      card_q <= 1'b0;
    end else begin
      wp_q <= wp_d;
      if (card_en) card_q <= card_d;
    end
  end
endmodule

// File: rtl/card_evt_latch.sv
module card_evt_latch
  import cdl_pkg::*;
#(
  parameter int          ADDR_W   = 4,
  parameter int          DATA_W   = 32,
  parameter int          SYNC_LEN = 2,
  parameter logic [31:0] ID_CONST = 32'h5A17_0C03,
  parameter logic [31:0] DEC_CONST = 32'h0000_0011
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err,
  input  logic              wp_in,
  input  logic              card_in,
  output logic              card_irq
);
  localparam int ID_W = (DATA_W < 32) ? DATA_W : 32;

  logic [SYNC_LEN-1:0] rst_pipe;
  logic                rst_q_n;
  word_hit_t           hit;
  logic                clr_card;
  logic                wp_q;
  logic                card_q;
  logic [DATA_W-1:0]   stat_word;
  logic                err_d;

  // reset: asserted asynchronously, released through a flop chain
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC_LEN-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC_LEN-1];

  cdl_decode #(.ADDR_W(ADDR_W)) u_decode (
    .sel        (bus_sel),
    .wr         (bus_wr),
    .addr       (bus_addr),
    .wdata_card (bus_wdata[CARD_POS]),
    .hit        (hit),
    .clr_card   (clr_card)
  );

  cdl_status u_status (
    .clk      (clk),
    .rst_q_n  (rst_q_n),
    .wp_in    (wp_in),
    .card_in  (card_in),
    .clr_card (clr_card),
    .wp_q     (wp_q),
    .card_q   (card_q)
  );

  always_comb begin
    stat_word           = '0;
    stat_word[WP_POS]   = wp_q;
    stat_word[CARD_POS] = card_q;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit.id)   bus_rdata[ID_W-1:0] = ID_CONST[ID_W-1:0];
    if (hit.stat) bus_rdata = stat_word;
    if (hit.dec)  bus_rdata[ID_W-1:0] = DEC_CONST[ID_W-1:0];
    err_d = hit.bad;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) bus_err <= 1'b0;
    else          bus_err <= err_d;
  end

  assign card_irq = card_q;
endmodule

// File: rtl/card_evt_latch_chk.sv
module card_evt_latch_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_q_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_err,
  input logic              wp_in,
  input logic              card_in,
  input logic              card_irq,
  input logic              wp_q
);
  logic bad_acc;
  logic clr_wr;
  assign bad_acc = bus_sel && (bus_addr >= ADDR_W'(4));
  assign clr_wr  = bus_sel && bus_wr && (bus_addr == ADDR_W'(2)) && bus_wdata[3];

  AST_WP_FOLLOW: assert property (@(posedge clk) disable iff (!rst_q_n)
    1'b1 |=> (wp_q == $past(wp_in))); // R2
  AST_CARD_SET: assert property (@(posedge clk) disable iff (!rst_q_n)
    card_in |=> card_irq); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    (card_irq && !clr_wr) |=> card_irq); // R3
  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (!card_irq && !card_in) |=> !card_irq); // R4
  AST_CLEAR: assert property (@(posedge clk) disable iff (!rst_q_n)
    (clr_wr && !card_in) |=> !card_irq); // R5
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_q_n)
    bad_acc |=> bus_err); // R9
  AST_ERR_ONLY_BAD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !bad_acc |=> !bus_err); // R9
endmodule

bind card_evt_latch card_evt_latch_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_err   (bus_err),
  .wp_in     (wp_in),
  .card_in   (card_in),
  .card_irq  (card_irq),
  .wp_q      (wp_q)
);

// File: tb/card_evt_latch_test.sv
module card_evt_latch_test;
  localparam int AW = 4;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0;
  logic          bus_wr = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic          bus_err;
  logic          wp_in = 1'b0;
  logic          card_in = 1'b0;
  logic          card_irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  card_evt_latch uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .wp_in(wp_in), .card_in(card_in), .card_irq(card_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  // one access; rdata captured in the access cycle, err after the edge
  task automatic bus_op(input logic wr, input logic [AW-1:0] a,
                        input logic [31:0] d, output logic [31:0] rd,
                        output logic err_after);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = d;
    #1 rd = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
    err_after = bus_err;
  endtask

  task automatic rd_stat(output logic [31:0] v);
    logic e;
    bus_op(1'b0, 4'd2, 32'h0, v, e);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    #1;
    check("R1 irq in reset", {31'b0, card_irq}, 0);
    check("R1 err in reset", {31'b0, bus_err}, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd_stat(v);
    check("R1 status after reset", v, 0);
    check("R1 irq after reset", {31'b0, card_irq}, 0);
  endtask

  task automatic t_ident;
    logic [31:0] v; logic e;
    bus_op(1'b0, 4'd0, 0, v, e); check("R7 id word", v, 32'h5A17_0C03);
    check("R9 no err on word 0", {31'b0, e}, 0);
    bus_op(1'b0, 4'd1, 0, v, e); check("R7 zero word", v, 0);
    bus_op(1'b0, 4'd3, 0, v, e); check("R7 decode word", v, 32'h11);
  endtask

  task automatic t_wp;
    logic [31:0] v;
    @(negedge clk); wp_in = 1'b1;
    rd_stat(v); check("R2 wp high", v, 32'h1);
    @(negedge clk); wp_in = 1'b0;
    rd_stat(v); check("R2 wp low", v, 32'h0);
    wp_in = 1'b1;
  endtask

  task automatic t_sticky;
    logic [31:0] v;
    @(negedge clk); card_in = 1'b1;
    @(negedge clk); card_in = 1'b0;
    check("R4 irq after insert", {31'b0, card_irq}, 1);
    repeat (2) @(negedge clk);
    rd_stat(v); check("R3 card bit sticky, R10 others zero", v, 32'h9);
    check("R4 irq held", {31'b0, card_irq}, 1);
  endtask

  task automatic t_clear;
    logic [31:0] v; logic e;
    bus_op(1'b1, 4'd2, 32'hFFFF_FFF7, v, e);
    check("R5 no clear without bit 3", {31'b0, card_irq}, 1);
    rd_stat(v); check("R5 status kept, wp untouched", v, 32'h9);
    bus_op(1'b1, 4'd2, 32'hFFFF_FFFF, v, e);
    check("R5 irq low after clear", {31'b0, card_irq}, 0);
    rd_stat(v); check("R5 card bit cleared, wp kept", v, 32'h1);
  endtask

  task automatic t_set_wins;
    logic [31:0] v;
    @(negedge clk);
    card_in = 1'b1;
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 4'd2; bus_wdata = 32'h8;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; card_in = 1'b0;
    check("R6 set wins irq", {31'b0, card_irq}, 1);
    rd_stat(v); check("R6 set wins status", v, 32'h9);
  endtask

  task automatic t_ignored;
    logic [31:0] v; logic e;
    bus_op(1'b1, 4'd1, 32'hFFFF_FFFF, v, e);
    check("R8 no err word 1 write", {31'b0, e}, 0);
    bus_op(1'b1, 4'd3, 32'hFFFF_FFFF, v, e);
    check("R8 no err word 3 write", {31'b0, e}, 0);
    bus_op(1'b0, 4'd1, 0, v, e); check("R8 word 1 still zero", v, 0);
    bus_op(1'b0, 4'd3, 0, v, e); check("R8 word 3 still 0x11", v, 32'h11);
    check("R8 irq unchanged", {31'b0, card_irq}, 1);
    rd_stat(v); check("R8 status unchanged", v, 32'h9);
  endtask

  task automatic t_bad;
    logic [31:0] v; logic e;
    bus_op(1'b0, 4'd4, 0, v, e);
    check("R9 bad read data", v, 0);
    check("R9 err pulse", {31'b0, e}, 1);
    @(negedge clk);
    check("R9 err one cycle", {31'b0, bus_err}, 0);
    bus_op(1'b1, 4'd15, 32'hFFFF_FFFF, v, e);
    check("R9 err on bad write", {31'b0, e}, 1);
    rd_stat(v); check("R9 bad write no effect", v, 32'h9);
  endtask

  initial begin
    t_reset();
    t_ident();
    t_wp();
    t_sticky();
    t_clear();
    t_set_wins();
    t_ignored();
    t_bad();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule